// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

This peripheral watches a system for a stall. It keeps a 32-bit down-counter that advances on a reference tick input and sits behind a small 32-bit register bus. Software keeps the system alive by writing a fresh tick count into the timer register. A two-bit action field in the control register sets what happens if the count is allowed to run out: nothing, a level interrupt, a single-cycle non-maskable interrupt, or a chip reset request.

The two registers are at fixed offsets. The control register is at offset 0x0 and the timer register is at offset 0x4. A value written to the timer register passes through a short settling pipeline before it replaces the live count. For that reason software writes the timer first and arms the action afterwards.

A sticky flag in the control register records that the watchdog has requested a chip reset. Only the power-on reset input clears it, so the flag survives the reset that the watchdog itself causes.

Top module: `wdog_action_timer`

## Requirements
- R1: After power-on reset the count is 0, the action field is 0, the sticky flag is 0, and irq, nmi and rst_req are low.
- R2: The control register is at byte offset 0x0. Bits [1:0] hold the action and bit 31 holds the sticky flag. Every other control bit reads 0. The timer register is at offset 0x4. Any other offset reads 0 and ignores writes.
- R3: A timer write reaches the count on the second clock edge after the edge that captures the write. Timer reads before that edge return the old count.
- R4: While the action is non-zero, the count drops by one on each clock edge where ref_tick is high. While the action is 0, the count holds.
- R5: The count never wraps below zero. Once it reaches 0 it stays at 0 until a timer write takes effect.
- R6: Action 1: when the count steps from 1 to 0, irq goes high in that cycle. It stays high until a timer reload reaches the count.
- R7: Action 2: when the count steps from 1 to 0, nmi is high for exactly one cycle.
- R8: Action 3: when the count steps from 1 to 0, rst_req is high for exactly 16 cycles, and the sticky flag is set in the same cycle.
- R9: Bus writes never change the sticky flag. Only power-on reset clears it.
- R10: With action 0, the count reaching 0 raises none of irq, nmi or rst_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ref_tick | input | 1 | Reference tick, one count step per high cycle |
| irq | output | 1 | Level interrupt (action 1) |
| nmi | output | 1 | One-cycle non-maskable interrupt (action 2) |
| rst_req | output | 1 | Chip reset request, 16 cycles (action 3) |

## Verification
The bench sweeps all four action codes against starting counts 1 through 6, with the tick held high on every cycle. This pins the expiry cycle to exactly N edges after the tick starts, and a count off by one in either direction shows up as a mismatch. Each run also reads the timer back in the two cycles after the write, which separates a correct settling delay from a load that lands too early or too late. The action-3 runs measure the width of the reset request and check that the sticky flag holds through later control writes. The action-1 runs reload the timer and check that irq drops only when the reload lands. Action 0 with the tick running shows that the count holds and that no output fires.

// File: rtl/wdog_action_timer.sv
module wdog_action_timer #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_HOLD    = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic              irq,
  output logic              nmi,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] TIMER_OFS = ADDR_W'(4);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [1:0] ACT_IRQ = 2'd1;
  localparam logic [1:0] ACT_NMI = 2'd2;
  localparam logic [1:0] ACT_RST = 2'd3;

  logic [1:0]              action;
  logic                    wd_flag;
  logic [DATA_W-1:0]       count;
  logic [SYNC_STAGES-1:0]  pvld;
  logic [DATA_W-1:0]       pval [SYNC_STAGES];
  logic [HOLD_W-1:0]       hold_cnt;

  wire wr_ctrl  = bus_sel && bus_wr && (bus_addr == CTRL_OFS);
  wire wr_timer = bus_sel && bus_wr && (bus_addr == TIMER_OFS);
  wire ld_fire  = pvld[SYNC_STAGES-1];
  wire armed    = (action != 2'd0);
  wire stepping = armed && ref_tick && (count != '0);
  wire expire   = !ld_fire && stepping && (count == DATA_W'(1));

  assign bus_rdata = (bus_addr == CTRL_OFS)  ? {wd_flag, {(DATA_W-3){1'b0}}, action} :
                     (bus_addr == TIMER_OFS) ? count : '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) action <= 2'd0;
    else if (wr_ctrl) action <= bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pvld <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) pval[s] <= '0;
    end else begin
      pvld[0] <= wr_timer;
      pval[0] <= bus_wdata;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        pvld[s] <= pvld[s-1];
        pval[s] <= pval[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) count <= '0;
    else if (ld_fire) count <= pval[SYNC_STAGES-1];
    else if (stepping) count <= count - DATA_W'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) irq <= 1'b0;
    else if (ld_fire) irq <= 1'b0;
    else if (expire && action == ACT_IRQ) irq <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) nmi <= 1'b0;
    else nmi <= expire && (action == ACT_NMI);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_req  <= 1'b0;
      hold_cnt <= '0;
    end else if (expire && action == ACT_RST) begin
      rst_req  <= 1'b1;
      hold_cnt <= HOLD_W'(RST_HOLD - 1);
    end else if (rst_req) begin
      if (hold_cnt == '0) rst_req <= 1'b0;
      else hold_cnt <= hold_cnt - HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) wd_flag <= 1'b0;
    else if (expire && action == ACT_RST) wd_flag <= 1'b1;
  end

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && !ld_fire) |=> (count == $past(count)));
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!por_n)
    (count == '0 && !ld_fire) |=> (count == '0));
  p_irq_reload_r6: assert property (@(posedge clk) disable iff (!por_n)
    ld_fire |=> !irq);
  p_nmi_single_r7: assert property (@(posedge clk) disable iff (!por_n)
    nmi |=> !nmi);
  p_rst_flags_r8: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> wd_flag);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    wd_flag |=> wd_flag);
  p_silent_r10: assert property (@(posedge clk) disable iff (!por_n)
    (!armed && !irq && !nmi && !rst_req) |=> (!nmi && !rst_req && !$rose(irq)));
endmodule

// File: tb/test_wdog_action_timer.sv
`timescale 1ns/1ps
module test_wdog_action_timer;
  logic clk = 0, por_n = 0, bus_sel = 0, bus_wr = 0, ref_tick = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, nmi, rst_req;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  wdog_action_timer i_wdog_action_timer (
    .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_tick(ref_tick), .irq(irq), .nmi(nmi), .rst_req(rst_req));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_por();
    ref_tick = 0;
    @(negedge clk); por_n = 0;
    @(negedge clk); @(negedge clk); por_n = 1;
  endtask

  task automatic run(int a, int n);
    logic [31:0] d;
    int hc;
    do_por();
    wr(3'h0, 32'(a));
    wr(3'h4, 32'(n));
    rd(3'h4, d); chk("R3 old value window 1", d, 0);
    @(negedge clk); rd(3'h4, d); chk("R3 old value window 2", d, 0);
    @(negedge clk); rd(3'h4, d); chk("R3 value landed", d, 32'(n));
    ref_tick = 1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); rd(3'h4, d);
      chk("R4 count step", d, (a == 0) ? 32'(n) : 32'(n - i));
      if (i == n - 1) chk("R10 no early output", {irq, nmi, rst_req}, 0);
    end
    chk("R6 irq at expiry", irq, (a == 1));
    chk("R7 nmi at expiry", nmi, (a == 2));
    chk("R8 rst at expiry", rst_req, (a == 3));
    if (a == 0) chk("R10 silent", {irq, nmi, rst_req}, 0);
    hc = rst_req;
    @(negedge clk); rd(3'h4, d);
    chk("R5 stays at zero", d, (a == 0) ? 32'(n) : 0);
    chk("R7 nmi one cycle", nmi, 0);
    chk("R6 irq held", irq, (a == 1));
    if (rst_req) hc++;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (rst_req) hc++;
    end
    rd(3'h4, d); chk("R5 no wrap", d, (a == 0) ? 32'(n) : 0);
    chk("R8 rst width", 32'(hc), (a == 3) ? 16 : 0);
    rd(3'h0, d); chk("R8 flag set", d[31], (a == 3));
    if (a == 1) begin
      ref_tick = 0;
      wr(3'h4, 32'd9);
      chk("R6 irq before reload lands", irq, 1);
      @(negedge clk); chk("R6 irq before reload lands 2", irq, 1);
      @(negedge clk); chk("R6 irq cleared by reload", irq, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: run hung");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_por();
    rd(3'h0, d); chk("R1 ctrl after reset", d, 0);
    rd(3'h4, d); chk("R1 count after reset", d, 0);
    chk("R1 outputs after reset", {irq, nmi, rst_req}, 0);
    wr(3'h0, 32'hFFFF_FFFF);
    rd(3'h0, d); chk("R2 reserved bits read 0", d, 32'h3);
    wr(3'h2, 32'h1234_5678);
    rd(3'h2, d); chk("R2 unmapped offset", d, 0);
    @(negedge clk); @(negedge clk);
    rd(3'h4, d); chk("R2 unmapped write ignored", d, 0);
    for (int a = 0; a < 4; a++)
      for (int n = 1; n <= 6; n++) run(a, n);
    wr(3'h0, 32'h0);
    rd(3'h0, d); chk("R9 flag survives write", d, 32'h8000_0000);
    wr(3'h0, 32'h8000_0000);
    rd(3'h0, d); chk("R9 flag unchanged by bit31 write", d, 32'h8000_0000);
    do_por();
    rd(3'h0, d); chk("R9 flag cleared by por", d, 0);
    do_por();
    wr(3'h4, 32'd5);
    @(negedge clk); @(negedge clk);
    ref_tick = 1;
    for (int k = 0; k < 8; k++) @(negedge clk);
    rd(3'h4, d); chk("R4 hold with action 0", d, 5);
    chk("R10 no output with action 0", {irq, nmi, rst_req}, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule